// File: doc/BRIEF.md
# 16-bit Register Pair Arithmetic Unit

This unit carries out the 16-bit pair operations of an 8-bit processor core. It covers four operations. A pair can be loaded from a two-byte immediate, incremented or decremented by one, or added into the H:L pair. The four pairs are BC, DE, HL and SP. The core presents an opcode, the immediate bytes, the current values of all four pairs and the current flags, then pulses `start`. The unit latches these operands and spends one machine cycle of `MCYCLE_CLKS` clocks per cycle that the instruction costs. It then raises `done` for one clock, together with the write-back pair index, the new pair value, the new flag nibble and the machine-cycle count.

The flag rules differ from operation to operation. Increment and decrement never touch a flag. The add into H:L keeps Z, clears N, and derives half-carry from the carry out of the low twelve bits rather than the low four. Its carry flag is the carry out of bit 15. Every 16-bit result wraps modulo 65536. An opcode outside this group completes without a write, so the surrounding core can route every opcode here without filtering it first.

Top module: `pair_arith_unit`

## Requirements
- R1: Opcodes 0x01, 0x11, 0x21 and 0x31 load BC, DE, HL and SP with `{imm_hi, imm_lo}`, because the low byte arrives first. Opcode bits 5:4 select the pair, and `pair_sel` encodes 0=BC, 1=DE, 2=HL, 3=SP.
- R2: Opcodes 0x03, 0x13, 0x23 and 0x33 write the selected pair plus one, modulo 65536, so 0xFFFF becomes 0x0000.
- R3: Opcodes 0x0B, 0x1B, 0x2B and 0x3B write the selected pair minus one, modulo 65536, so 0x0000 becomes 0xFFFF.
- R4: The flag nibble is bit 3 Z, bit 2 N, bit 1 H and bit 0 C. For loads, increments and decrements, `flags_out` equals the `flags_in` value captured at start.
- R5: Opcodes 0x09, 0x19, 0x29 and 0x39 write HL + pair (BC, DE, HL, SP) modulo 65536 back to HL, with `pair_sel` = 2. Opcode 0x29 doubles HL.
- R6: After an add, H is set exactly when the sum of the low 12 bits of both operands exceeds 0xFFF. C is the carry out of bit 15, N is 0, and Z keeps its captured value.
- R7: `mcycles` reports 3 for a load and 2 for an increment, decrement or add. `done` rises `mcycles*MCYCLE_CLKS` clocks after the edge that accepts `start`.
- R8: `done` stays high for exactly one clock. `pair_we` is never high unless `done` is high.
- R9: Any other opcode completes after one machine cycle with `pair_we` = 0, `mcycles` = 1 and `flags_out` equal to the captured flags.
- R10: A `start` that arrives while `busy` is high is ignored. The running operation completes with its own operands and timing.
- R11: While reset is held and after it is released, `busy`, `done` and `pair_we` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; accepted only when idle |
| opcode | input | 8 | Instruction opcode |
| imm_lo | input | 8 | Immediate low byte |
| imm_hi | input | 8 | Immediate high byte |
| bc_in | input | 16 | Current BC |
| de_in | input | 16 | Current DE |
| hl_in | input | 16 | Current HL |
| sp_in | input | 16 | Current SP |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| pair_we | output | 1 | Write `pair_out` to the pair at `pair_sel` |
| pair_sel | output | 2 | Destination pair index |
| pair_out | output | 16 | New pair value |
| flags_out | output | 4 | New flags {Z,N,H,C} |
| mcycles | output | 2 | Machine cycles consumed |

## Verification
The in-RTL assertions check several rules on every clock. They confirm that `done` is a single pulse and that writes occur only with it. They confirm that increments, decrements and loads hand back their captured flags, and that an add keeps Z, clears N and targets HL. They also confirm that an accepted start raises `busy`. The arithmetic itself can only be shown by the bench's scenarios. These cover wrap at both ends of the range and the four half-carry/carry combinations of the add. The bench also checks clock-exact completion timing for each kind of operation and the rejection of a start issued mid-run.

// File: rtl/rpa_pkg.sv
package rpa_pkg;
  typedef enum logic [2:0] {
    OPK_NONE = 3'd0,
    OPK_LOAD = 3'd1,
    OPK_INC  = 3'd2,
    OPK_DEC  = 3'd3,
    OPK_ADD  = 3'd4
  } op_kind_e;

  // Flag nibble layout: bit3 Z, bit2 N, bit1 H, bit0 C
  localparam int FLAG_Z = 3;
  localparam int FLAG_N = 2;
  localparam int FLAG_H = 1;
  localparam int FLAG_C = 0;

  localparam logic [1:0] PAIR_BC = 2'd0;
  localparam logic [1:0] PAIR_DE = 2'd1;
  localparam logic [1:0] PAIR_HL = 2'd2;
  localparam logic [1:0] PAIR_SP = 2'd3;

  localparam int NUM_PAIRS = 4;
endpackage

// File: rtl/rpa_decode.sv
module rpa_decode
  import rpa_pkg::*;
(
  input  logic [7:0] opcode,
  output op_kind_e   kind,
  output logic [1:0] pair,
  output logic [1:0] mcyc
);
  always_comb begin
    pair = opcode[5:4];
    kind = OPK_NONE;
    mcyc = 2'd1;
    if (opcode[7:6] == 2'b00) begin
      case (opcode[3:0])
        4'h1: begin kind = OPK_LOAD; mcyc = 2'd3; end
        4'h3: begin kind = OPK_INC;  mcyc = 2'd2; end
        4'hB: begin kind = OPK_DEC;  mcyc = 2'd2; end
        4'h9: begin kind = OPK_ADD;  mcyc = 2'd2; end
        default: begin kind = OPK_NONE; mcyc = 2'd1; end
      endcase
    end
  end
endmodule

// File: rtl/rpa_opsel.sv
module rpa_opsel
  import rpa_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [NUM_PAIRS-1:0][W-1:0] pairs,
  input  logic [1:0]                  sel,
  output logic [W-1:0]                value
);
  logic [NUM_PAIRS-1:0][W-1:0] masked;

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_mask
    assign masked[g] = (sel == 2'(g)) ? pairs[g] : '0;
  end

  always_comb begin
    value = '0;
    for (int i = 0; i < NUM_PAIRS; i++) value = value | masked[i];
  end
endmodule

// File: rtl/rpa_exec.sv
module rpa_exec
  import rpa_pkg::*;
#(
  parameter int W = 16
) (
  input  op_kind_e     kind,
  input  logic [W-1:0] operand,
  input  logic [W-1:0] hl,
  input  logic [W-1:0] imm,
  input  logic [3:0]   flags_i,
  output logic [W-1:0] result,
  output logic [3:0]   flags_o,
  output logic         we
);
  localparam int HC_W = W - 4;

  logic [W:0]    full_sum;
  logic [HC_W:0] low_sum;

  assign full_sum = {1'b0, hl} + {1'b0, operand};
  assign low_sum  = {1'b0, hl[HC_W-1:0]} + {1'b0, operand[HC_W-1:0]};

  always_comb begin
    result  = operand;
    flags_o = flags_i;
    we      = 1'b1;
    case (kind)
      OPK_LOAD: result = imm;
      OPK_INC:  result = operand + W'(1);
      OPK_DEC:  result = operand - W'(1);
      OPK_ADD: begin
        result          = full_sum[W-1:0];
        flags_o[FLAG_N] = 1'b0;
        flags_o[FLAG_H] = low_sum[HC_W];
        flags_o[FLAG_C] = full_sum[W];
      end
      default: we = 1'b0;
    endcase
  end
endmodule

// File: rtl/rpa_seq.sv
module rpa_seq #(
  parameter int MCYCLE_CLKS = 4,
  parameter int MAX_MCYC    = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] mcyc,
  output logic       busy,
  output logic       accept,
  output logic       finish
);
  localparam int MAX_CLKS = MAX_MCYC * MCYCLE_CLKS;
  localparam int CNT_W    = $clog2(MAX_CLKS + 1);

  logic [CNT_W-1:0] cnt;

  assign accept = start && !busy;
  assign finish = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(mcyc * MCYCLE_CLKS - 1);
    end else if (finish) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy);  // R10
  AST_FINISH_IDLE: assert property (@(posedge clk) disable iff (rst)
    finish |=> !busy);  // R7
endmodule

// File: rtl/pair_arith_unit.sv
module pair_arith_unit
  import rpa_pkg::*;
#(
  parameter int W           = 16,
  parameter int MCYCLE_CLKS = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [7:0]   opcode,
  input  logic [7:0]   imm_lo,
  input  logic [7:0]   imm_hi,
  input  logic [W-1:0] bc_in,
  input  logic [W-1:0] de_in,
  input  logic [W-1:0] hl_in,
  input  logic [W-1:0] sp_in,
  input  logic [3:0]   flags_in,
  output logic         busy,
  output logic         done,
  output logic         pair_we,
  output logic [1:0]   pair_sel,
  output logic [W-1:0] pair_out,
  output logic [3:0]   flags_out,
  output logic [1:0]   mcycles
);
  op_kind_e     dec_kind, kind_q;
  logic [1:0]   dec_pair, dec_mcyc, pair_q, mcyc_q;
  logic [W-1:0] sel_value, operand_q, hl_q, imm_q;
  logic [3:0]   flags_q;
  logic         accept, finish;
  logic [W-1:0] ex_result;
  logic [3:0]   ex_flags;
  logic         ex_we;
  logic [NUM_PAIRS-1:0][W-1:0] pair_bus;

  assign pair_bus = {sp_in, hl_in, de_in, bc_in};

  rpa_decode u_decode (
    .opcode (opcode),
    .kind   (dec_kind),
    .pair   (dec_pair),
    .mcyc   (dec_mcyc)
  );

  rpa_opsel #(.W(W)) u_opsel (
    .pairs (pair_bus),
    .sel   (dec_pair),
    .value (sel_value)
  );

  rpa_seq #(.MCYCLE_CLKS(MCYCLE_CLKS), .MAX_MCYC(3)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .mcyc   (dec_mcyc),
    .busy   (busy),
    .accept (accept),
    .finish (finish)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q    <= OPK_NONE;
      pair_q    <= PAIR_BC;
      mcyc_q    <= 2'd1;
      operand_q <= '0;
      hl_q      <= '0;
      imm_q     <= '0;
      flags_q   <= '0;
    end else if (accept) begin
      kind_q    <= dec_kind;
      pair_q    <= dec_pair;
      mcyc_q    <= dec_mcyc;
      operand_q <= sel_value;
      hl_q      <= hl_in;
      imm_q     <= {imm_hi, imm_lo};
      flags_q   <= flags_in;
    end
  end

  rpa_exec #(.W(W)) u_exec (
    .kind    (kind_q),
    .operand (operand_q),
    .hl      (hl_q),
    .imm     (imm_q),
    .flags_i (flags_q),
    .result  (ex_result),
    .flags_o (ex_flags),
    .we      (ex_we)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      pair_we   <= 1'b0;
      pair_sel  <= PAIR_BC;
      pair_out  <= '0;
      flags_out <= '0;
      mcycles   <= '0;
    end else if (finish) begin
      done      <= 1'b1;
      pair_we   <= ex_we;
      pair_sel  <= (kind_q == OPK_ADD) ? PAIR_HL : pair_q;
      pair_out  <= ex_result;
      flags_out <= ex_flags;
      mcycles   <= mcyc_q;
    end else begin
      done    <= 1'b0;
      pair_we <= 1'b0;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R8
  AST_WE_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    pair_we |-> done);  // R8
  AST_STEP_FLAGS_KEPT: assert property (@(posedge clk) disable iff (rst)
    done && (kind_q == OPK_INC || kind_q == OPK_DEC || kind_q == OPK_LOAD)
      |-> flags_out == flags_q);  // R4
  AST_ADD_Z_N: assert property (@(posedge clk) disable iff (rst)
    done && kind_q == OPK_ADD
      |-> flags_out[FLAG_Z] == flags_q[FLAG_Z] && !flags_out[FLAG_N]);  // R6
  AST_ADD_TO_HL: assert property (@(posedge clk) disable iff (rst)
    done && kind_q == OPK_ADD |-> pair_we && pair_sel == PAIR_HL);  // R5
  AST_OTHER_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    done && kind_q == OPK_NONE |-> !pair_we && mcycles == 2'd1);  // R9
  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> !busy && !done && !pair_we);  // R11
endmodule

// File: tb/pair_arith_unit_bench.sv
module pair_arith_unit_bench;
  localparam int MCK = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0, imm_lo = '0, imm_hi = '0;
  logic [15:0] bc_in = '0, de_in = '0, hl_in = '0, sp_in = '0;
  logic [3:0]  flags_in = '0;
  logic        busy, done, pair_we;
  logic [1:0]  pair_sel, mcycles;
  logic [15:0] pair_out;
  logic [3:0]  flags_out;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  pair_arith_unit #(.W(16), .MCYCLE_CLKS(MCK)) u_pair_arith_unit (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode),
    .imm_lo(imm_lo), .imm_hi(imm_hi), .bc_in(bc_in), .de_in(de_in),
    .hl_in(hl_in), .sp_in(sp_in), .flags_in(flags_in),
    .busy(busy), .done(done), .pair_we(pair_we), .pair_sel(pair_sel),
    .pair_out(pair_out), .flags_out(flags_out), .mcycles(mcycles)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected behaviour computed from the requirements
  task automatic model(input logic [7:0] op, input logic [15:0] bc, de, hl, sp,
                       input logic [7:0] lo, hi, input logic [3:0] f,
                       output logic we, output logic [1:0] sel,
                       output logic [15:0] val, output logic [3:0] fo,
                       output int mc, output string req);
    logic [15:0] p;
    logic [16:0] s;
    logic [12:0] ls;
    case (op[5:4])
      2'd0: p = bc;
      2'd1: p = de;
      2'd2: p = hl;
      default: p = sp;
    endcase
    we = 1'b1; sel = op[5:4]; fo = f; val = p; mc = 2;
    if (op[7:6] != 2'b00) begin
      we = 1'b0; mc = 1; req = "R9";
    end else if (op[3:0] == 4'h1) begin
      val = {hi, lo}; mc = 3; req = "R1";
    end else if (op[3:0] == 4'h3) begin
      val = p + 16'd1; req = "R2";
    end else if (op[3:0] == 4'hB) begin
      val = p - 16'd1; req = "R3";
    end else if (op[3:0] == 4'h9) begin
      s = {1'b0, hl} + {1'b0, p};
      ls = {1'b0, hl[11:0]} + {1'b0, p[11:0]};
      val = s[15:0]; sel = 2'd2;
      fo = {f[3], 1'b0, ls[12], s[16]};
      req = "R5";
    end else begin
      we = 1'b0; mc = 1; req = "R9";
    end
  endtask

  task automatic run_op(input logic [7:0] op, input logic [15:0] bc, de, hl, sp,
                        input logic [7:0] lo, hi, input logic [3:0] f,
                        input bit intrude);
    logic e_we; logic [1:0] e_sel; logic [15:0] e_val; logic [3:0] e_f;
    int e_mc; string rq; int n;
    model(op, bc, de, hl, sp, lo, hi, f, e_we, e_sel, e_val, e_f, e_mc, rq);
    @(negedge clk);
    opcode = op; bc_in = bc; de_in = de; hl_in = hl; sp_in = sp;
    imm_lo = lo; imm_hi = hi; flags_in = f; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    n = 0;
    while (!done && n < 64) begin
      if (intrude && n == 2) begin
        start = 1'b1; opcode = 8'h2B; bc_in = 16'h5555; imm_lo = 8'hEE;
      end else begin
        start = 1'b0;
      end
      @(posedge clk); #1;
      n++;
    end
    start = 1'b0;
    chk("R7 latency", n, e_mc * MCK);
    chk("R7 mcycles", mcycles, e_mc);
    chk("R8 write enable", pair_we, e_we);
    if (e_we) begin
      chk({rq, " pair_sel"}, pair_sel, e_sel);
      chk({rq, " value"}, pair_out, e_val);
    end
    chk((rq == "R5") ? "R6 flags" : "R4 flags", flags_out, e_f);
    @(posedge clk); #1;
    chk("R8 single pulse", {done, pair_we}, 0);
    if (intrude) chk("R10 idle after", busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] base [4];
    base[0] = 8'h01; base[1] = 8'h03; base[2] = 8'h0B; base[3] = 8'h09;
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset outputs", {busy, done, pair_we}, 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R11 after reset", {busy, done, pair_we}, 0);

    // Directed corners
    run_op(8'h11, 16'h0, 16'hAAAA, 16'h0, 16'h0, 8'h34, 8'h12, 4'b0101, 0); // R1
    run_op(8'h31, 16'h0, 16'h0, 16'h0, 16'h0, 8'hFE, 8'hFF, 4'b1111, 0);    // R1 SP
    run_op(8'h03, 16'hFFFF, 16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 4'b1111, 0);  // R2 wrap
    run_op(8'h33, 16'h0, 16'h0, 16'h0, 16'hFFFF, 8'h0, 8'h0, 4'b0000, 0);  // R2 wrap SP
    run_op(8'h1B, 16'h0, 16'h0000, 16'h0, 16'h0, 8'h0, 8'h0, 4'b1010, 0);  // R3 wrap
    run_op(8'h2B, 16'h0, 16'h0, 16'h0000, 16'h0, 8'h0, 8'h0, 4'b0101, 0);  // R3 wrap HL
    run_op(8'h09, 16'h0001, 16'h0, 16'h0FFF, 16'h0, 8'h0, 8'h0, 4'b1100, 0); // R6 H only
    run_op(8'h19, 16'h0, 16'h1000, 16'hF000, 16'h0, 8'h0, 8'h0, 4'b0011, 0); // R6 C only
    run_op(8'h39, 16'h0, 16'h0, 16'hFFFF, 16'h0001, 8'h0, 8'h0, 4'b1000, 0); // R6 both
    run_op(8'h09, 16'h0101, 16'h0, 16'h1234, 16'h0, 8'h0, 8'h0, 4'b1111, 0); // R6 neither
    run_op(8'h29, 16'h0, 16'h0, 16'h8800, 16'h0, 8'h0, 8'h0, 4'b0000, 0);  // R5 double
    run_op(8'h00, 16'h1, 16'h2, 16'h3, 16'h4, 8'h0, 8'h0, 4'b1001, 0);     // R9
    run_op(8'h76, 16'h1, 16'h2, 16'h3, 16'h4, 8'h0, 8'h0, 4'b0110, 0);     // R9
    run_op(8'h21, 16'h0, 16'h0, 16'h0, 16'h0, 8'hCD, 8'hAB, 4'b0010, 1);   // R10 intrusion

    // Constrained random
    for (int i = 0; i < 300; i++) begin
      int k = int'($urandom % 20);
      logic [7:0] op;
      logic [15:0] v [4];
      if (k < 16) op = base[k / 4] | 8'((k % 4) << 4);
      else        op = 8'($urandom);
      for (int j = 0; j < 4; j++) begin
        case ($urandom % 6)
          0: v[j] = 16'hFFFF;
          1: v[j] = 16'h0000;
          2: v[j] = 16'h0FFF;
          default: v[j] = 16'($urandom);
        endcase
      end
      run_op(op, v[0], v[1], v[2], v[3], 8'($urandom), 8'($urandom),
             4'($urandom), 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule